// File: doc/BRIEF.md
# Multi-Mode Operand Address Generator

This block turns the addressing fields of one instruction into a memory operand. A 4-bit mode code selects how the effective address is formed from a base register value, an index register value, a constant taken from the instruction and a 2-bit scale shift. The block then reads the operand through a simple synchronous memory read port, or returns a register or constant value directly when no memory access is needed. A pointer-chasing mode reads memory twice: first the pointer, then the operand it points to. A post-increment mode also sends an updated base value to a register write-back port.

The controller is a four-state machine.

- **IDLE**: waits for `start`. On a start it latches the request and moves to FINISH for modes that need no memory access, or to ISSUE for all others.
- **ISSUE**: drives one read request for a single cycle, then always moves to CATCH.
- **CATCH**: takes the returned read data. In the pointer-chasing mode, when the pointer has not yet been fetched, the data becomes the new address and the state goes back to ISSUE. In every other case the data becomes the result and the state moves to FINISH.
- **FINISH**: raises `done` for one cycle, then returns to IDLE.

Top module: `opaddr_gen`

## Requirements
- R1: Mode code 0 (register) returns `base_val` on `result` with `eff_addr` 0, makes no memory read, and raises `done` in the first cycle after the clock edge that accepts `start`.
- R2: Mode code 1 (immediate) returns `konst` on `result`, makes no memory read, and has the same one-cycle latency as R1.
- R3: Mode code 2 (register indirect) makes exactly one read at address `base_val`; `result` is the read data and `eff_addr` is `base_val`. `done` appears in the third cycle after acceptance.
- R4: Mode code 3 (displacement) reads at `base_val + konst`, modulo 2^DW.
- R5: Mode code 4 (indexed) reads at `base_val + index_val`, modulo 2^DW.
- R6: Mode code 5 (direct) reads at `konst`.
- R7: Mode code 6 (memory indirect) makes exactly two reads. The first is at `base_val`; the second is at the data returned by the first. `result` is the second data and `eff_addr` is the second address. `done` appears in the fifth cycle after acceptance.
- R8: Mode code 7 (auto-increment) reads at `base_val` and, during the `done` cycle, asserts `wb_en` with `wb_data = base_val + op_size`, modulo 2^DW. `wb_en` stays low in all other modes and cycles.
- R9: Mode code 8 (scaled) reads at `konst + base_val + (index_val << scale_sh)`, with `scale_sh` from 0 to 3 giving factors 1, 2, 4 and 8.
- R10: `start` is ignored while `busy` is high. `busy` rises after the accepting edge and stays high up to and including the `done` cycle.
- R11: After reset, `busy`, `done`, `mem_rd_en` and `wb_en` are low. `done` is high for exactly one cycle per accepted operation.
- R12: Mode codes 9 to 15 behave as register mode (R1).
- R13: Each read drives `mem_rd_en` high for one cycle with `mem_addr`. The block takes `mem_rdata` in the cycle that follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins an operation when idle |
| mode | input | 4 | Addressing mode code |
| base_val | input | DW | Base register content |
| index_val | input | DW | Index register content |
| konst | input | DW | Constant from the instruction |
| scale_sh | input | 2 | Index shift amount (0 to 3) |
| op_size | input | SW | Operand size in bytes, used as the increment |
| mem_rd_en | output | 1 | Memory read request |
| mem_addr | output | DW | Memory read address |
| mem_rdata | input | DW | Read data, valid one cycle after the request |
| wb_en | output | 1 | Base register write-back strobe |
| wb_data | output | DW | Updated base register value |
| done | output | 1 | Result valid, one-cycle pulse |
| result | output | DW | Operand value |
| eff_addr | output | DW | Last memory address used |
| busy | output | 1 | Operation in progress |

## Verification
The bench builds the block with DW = 16 and SW = 4. With a 16-bit width, the wrap of a displacement sum and of the auto-increment write-back can be reached with small input values such as 0xFFFE + 8. The memory model returns a byte-swapped and scrambled copy of the address. Because of this, each hop of the memory-indirect chain lands on a distinct, predictable address, and a read at the wrong address or a read of stale data shows up in the result.

// File: rtl/opaddr_pkg.sv
package opaddr_pkg;

    typedef enum logic [3:0] {
        AM_REG  = 4'd0,
        AM_IMM  = 4'd1,
        AM_RIND = 4'd2,
        AM_DISP = 4'd3,
        AM_INDX = 4'd4,
        AM_ABS  = 4'd5,
        AM_MIND = 4'd6,
        AM_AINC = 4'd7,
        AM_SCAL = 4'd8
    } amode_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_CATCH,
        ST_FINISH
    } ctl_state_e;

    // Codes beyond the defined set fall back to register mode
    function automatic amode_e decode_mode(input logic [3:0] code);
        if (code > 4'd8) return AM_REG;
        return amode_e'(code);
    endfunction

    function automatic logic mode_no_mem(input amode_e m);
        return (m == AM_REG) || (m == AM_IMM);
    endfunction

endpackage

// File: rtl/opaddr_ea_calc.sv
module opaddr_ea_calc
    import opaddr_pkg::*;
#(
    parameter int DW  = 16,
    parameter int SHW = 2
) (
    input  amode_e          amode,
    input  logic [DW-1:0]   base_val,
    input  logic [DW-1:0]   index_val,
    input  logic [DW-1:0]   konst,
    input  logic [SHW-1:0]  scale_sh,
    output logic [DW-1:0]   ea
);

    logic [DW-1:0] scaled_idx;

    assign scaled_idx = index_val << scale_sh;

    always_comb begin
        unique case (amode)
            AM_RIND, AM_MIND, AM_AINC: ea = base_val;
            AM_DISP:                   ea = base_val + konst;
            AM_INDX:                   ea = base_val + index_val;
            AM_ABS:                    ea = konst;
            AM_SCAL:                   ea = konst + base_val + scaled_idx;
            default:                   ea = '0;
        endcase
    end

endmodule

// File: rtl/opaddr_seq.sv
module opaddr_seq
    import opaddr_pkg::*;
#(
    parameter int DW = 16,
    parameter int SW = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  amode_e         amode,
    input  logic [DW-1:0]  base_val,
    input  logic [DW-1:0]  konst,
    input  logic [SW-1:0]  op_size,
    input  logic [DW-1:0]  ea_in,
    input  logic [DW-1:0]  mem_rdata,
    output logic           mem_rd_en,
    output logic [DW-1:0]  mem_addr,
    output logic           wb_en,
    output logic [DW-1:0]  wb_data,
    output logic           done,
    output logic [DW-1:0]  result,
    output logic [DW-1:0]  eff_addr,
    output logic           busy
);

    localparam int PADW = DW - SW;

    ctl_state_e    state_q, state_d;
    amode_e        mode_q;
    logic [DW-1:0] addr_q;
    logic [DW-1:0] res_q;
    logic [DW-1:0] base_q;
    logic [SW-1:0] size_q;
    logic          ptr_done_q;
    logic          accept;
    logic          chase;

    assign accept = (state_q == ST_IDLE) && start;
    assign chase  = (mode_q == AM_MIND) && !ptr_done_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = mode_no_mem(amode) ? ST_FINISH : ST_ISSUE;
            ST_ISSUE:  state_d = ST_CATCH;
            ST_CATCH:  state_d = chase ? ST_ISSUE : ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Operation registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q     <= AM_REG;
            addr_q     <= '0;
            res_q      <= '0;
            base_q     <= '0;
            size_q     <= '0;
            ptr_done_q <= 1'b0;
        end else if (accept) begin
            mode_q     <= amode;
            addr_q     <= ea_in;
            res_q      <= (amode == AM_IMM) ? konst : base_val;
            base_q     <= base_val;
            size_q     <= op_size;
            ptr_done_q <= 1'b0;
        end else if (state_q == ST_CATCH) begin
            if (chase) begin
                addr_q     <= mem_rdata;
                ptr_done_q <= 1'b1;
            end else begin
                res_q <= mem_rdata;
            end
        end
    end

    // Outputs
    always_comb begin
        mem_rd_en = (state_q == ST_ISSUE);
        mem_addr  = addr_q;
        done      = (state_q == ST_FINISH);
        wb_en     = (state_q == ST_FINISH) && (mode_q == AM_AINC);
        wb_data   = base_q + {{PADW{1'b0}}, size_q};
        result    = res_q;
        eff_addr  = addr_q;
        busy      = (state_q != ST_IDLE);
    end

endmodule

// File: rtl/opaddr_gen.sv
module opaddr_gen
    import opaddr_pkg::*;
#(
    parameter int DW = 16,
    parameter int SW = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [3:0]     mode,
    input  logic [DW-1:0]  base_val,
    input  logic [DW-1:0]  index_val,
    input  logic [DW-1:0]  konst,
    input  logic [1:0]     scale_sh,
    input  logic [SW-1:0]  op_size,
    output logic           mem_rd_en,
    output logic [DW-1:0]  mem_addr,
    input  logic [DW-1:0]  mem_rdata,
    output logic           wb_en,
    output logic [DW-1:0]  wb_data,
    output logic           done,
    output logic [DW-1:0]  result,
    output logic [DW-1:0]  eff_addr,
    output logic           busy
);

    amode_e        amode;
    logic [DW-1:0] ea_w;

    assign amode = decode_mode(mode);

    opaddr_ea_calc #(.DW(DW), .SHW(2)) ea_i (
        .amode     (amode),
        .base_val  (base_val),
        .index_val (index_val),
        .konst     (konst),
        .scale_sh  (scale_sh),
        .ea        (ea_w)
    );

    opaddr_seq #(.DW(DW), .SW(SW)) seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .amode     (amode),
        .base_val  (base_val),
        .konst     (konst),
        .op_size   (op_size),
        .ea_in     (ea_w),
        .mem_rdata (mem_rdata),
        .mem_rd_en (mem_rd_en),
        .mem_addr  (mem_addr),
        .wb_en     (wb_en),
        .wb_data   (wb_data),
        .done      (done),
        .result    (result),
        .eff_addr  (eff_addr),
        .busy      (busy)
    );

endmodule

// File: rtl/opaddr_chk.sv
module opaddr_chk (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic done,
    input logic mem_rd_en,
    input logic wb_en
);

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                 // R11

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!done && !mem_rd_en && !wb_en));      // R11

    AST_WB_ONLY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> done);                                 // R8

    AST_READ_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> !mem_rd_en);                       // R13

    AST_DONE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);                                 // R10

    AST_NO_READ_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_rd_en);                            // R13

endmodule

bind opaddr_gen opaddr_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .done      (done),
    .mem_rd_en (mem_rd_en),
    .wb_en     (wb_en)
);

// File: tb/opaddr_gen_tb_top.sv
module opaddr_gen_tb_top;

    localparam int DW = 16;
    localparam int SW = 4;

    typedef struct packed {
        logic [DW-1:0] res;
        logic [DW-1:0] ea;
        logic          wb;
        logic [DW-1:0] wbd;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [3:0]    mode = '0;
    logic [DW-1:0] base_val = '0;
    logic [DW-1:0] index_val = '0;
    logic [DW-1:0] konst = '0;
    logic [1:0]    scale_sh = '0;
    logic [SW-1:0] op_size = '0;
    logic          mem_rd_en;
    logic [DW-1:0] mem_addr;
    logic [DW-1:0] mem_rdata = '0;
    logic          wb_en;
    logic [DW-1:0] wb_data;
    logic          done;
    logic [DW-1:0] result;
    logic [DW-1:0] eff_addr;
    logic          busy;

    int   checks = 0;
    int   errors = 0;
    int   rd_cnt = 0;
    exp_t exp_q[$];
    string tag_q[$];

    always #2.5 clk = ~clk;

    opaddr_gen #(.DW(DW), .SW(SW)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .base_val(base_val), .index_val(index_val), .konst(konst),
        .scale_sh(scale_sh), .op_size(op_size),
        .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .wb_en(wb_en), .wb_data(wb_data), .done(done), .result(result),
        .eff_addr(eff_addr), .busy(busy)
    );

    function automatic logic [DW-1:0] memf(input logic [DW-1:0] a);
        return {a[7:0], a[15:8]} ^ 16'h3C96;
    endfunction

    // Memory model: one-cycle read latency
    always @(posedge clk) begin
        if (mem_rd_en) begin
            mem_rdata <= memf(mem_addr);
            rd_cnt    <= rd_cnt + 1;
        end
    end

    task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R10 done without accepted start", 32'(done), 32'd0);
            end else begin
                exp_t  e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(result == e.res, {t, " result"}, 32'(result), 32'(e.res));
                check(eff_addr == e.ea, {t, " eff_addr"}, 32'(eff_addr), 32'(e.ea));
                check(wb_en == e.wb, {t, " R8 wb_en"}, 32'(wb_en), 32'(e.wb));
                if (e.wb) check(wb_data == e.wbd, {t, " R8 wb_data"}, 32'(wb_data), 32'(e.wbd));
            end
        end
    end

    task automatic run_op(input logic [3:0] m, input logic [DW-1:0] b, input logic [DW-1:0] ix,
                          input logic [DW-1:0] k, input logic [1:0] sh, input logic [SW-1:0] sz,
                          input exp_t e, input int exp_lat, input int exp_rd, input string tag);
        int r0;
        int lat;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        mode = m; base_val = b; index_val = ix; konst = k; scale_sh = sh; op_size = sz;
        start = 1'b1;
        r0 = rd_cnt;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 20) begin
            @(negedge clk);
            lat++;
        end
        check(lat == exp_lat, {tag, " latency"}, 32'(lat), 32'(exp_lat));
        check((rd_cnt - r0) == exp_rd, {tag, " read count"}, 32'(rd_cnt - r0), 32'(exp_rd));
    endtask

    function automatic exp_t mk(input logic [DW-1:0] r, input logic [DW-1:0] a,
                                input logic w, input logic [DW-1:0] wd);
        exp_t e;
        e.res = r; e.ea = a; e.wb = w; e.wbd = wd;
        return e;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [DW-1:0] p;
        repeat (3) @(negedge clk);
        check(!busy && !done && !mem_rd_en && !wb_en, "R11 reset state",
              {28'd0, busy, done, mem_rd_en, wb_en}, 32'd0);
        rst_n = 1'b1;

        run_op(4'd0, 16'h1234, 16'h0, 16'h5555, 2'd0, 4'd2, mk(16'h1234, 16'h0, 1'b0, 16'h0), 1, 0, "R1 register");
        run_op(4'd12, 16'h0BEE, 16'h1, 16'h2222, 2'd1, 4'd2, mk(16'h0BEE, 16'h0, 1'b0, 16'h0), 1, 0, "R12 undefined code");
        run_op(4'd15, 16'h7001, 16'h1, 16'h2222, 2'd1, 4'd2, mk(16'h7001, 16'h0, 1'b0, 16'h0), 1, 0, "R12 code 15");
        run_op(4'd1, 16'h1111, 16'h0, 16'h7F01, 2'd0, 4'd2, mk(16'h7F01, 16'h0, 1'b0, 16'h0), 1, 0, "R2 immediate");
        run_op(4'd2, 16'h0040, 16'h9, 16'h0009, 2'd0, 4'd2, mk(memf(16'h0040), 16'h0040, 1'b0, 16'h0), 3, 1, "R3 reg indirect R13");
        run_op(4'd3, 16'h0100, 16'h9, 16'h0023, 2'd0, 4'd2, mk(memf(16'h0123), 16'h0123, 1'b0, 16'h0), 3, 1, "R4 displacement");
        run_op(4'd3, 16'hFFF0, 16'h9, 16'h0020, 2'd0, 4'd2, mk(memf(16'h0010), 16'h0010, 1'b0, 16'h0), 3, 1, "R4 displacement wrap");
        run_op(4'd4, 16'h2000, 16'h0345, 16'h0777, 2'd2, 4'd2, mk(memf(16'h2345), 16'h2345, 1'b0, 16'h0), 3, 1, "R5 indexed");
        run_op(4'd5, 16'h4444, 16'h1, 16'h0ABC, 2'd0, 4'd2, mk(memf(16'h0ABC), 16'h0ABC, 1'b0, 16'h0), 3, 1, "R6 direct");
        p = memf(16'h0077);
        run_op(4'd6, 16'h0077, 16'h1, 16'h0005, 2'd0, 4'd2, mk(memf(p), p, 1'b0, 16'h0), 5, 2, "R7 memory indirect");
        run_op(4'd7, 16'h0300, 16'h1, 16'h0005, 2'd0, 4'd4, mk(memf(16'h0300), 16'h0300, 1'b1, 16'h0304), 3, 1, "R8 auto-increment");
        run_op(4'd7, 16'hFFFE, 16'h1, 16'h0005, 2'd0, 4'd8, mk(memf(16'hFFFE), 16'hFFFE, 1'b1, 16'h0006), 3, 1, "R8 auto-increment wrap");
        for (int s = 0; s < 4; s++) begin
            logic [DW-1:0] a;
            a = 16'h0010 + 16'h1000 + (16'd3 << s);
            run_op(4'd8, 16'h1000, 16'h0003, 16'h0010, 2'(s), 4'd2, mk(memf(a), a, 1'b0, 16'h0), 3, 1, "R9 scaled");
        end

        // R10: a second start while busy must not launch an operation
        exp_q.push_back(mk(memf(16'h0050), 16'h0050, 1'b0, 16'h0));
        tag_q.push_back("R10 start while busy");
        @(negedge clk);
        mode = 4'd2; base_val = 16'h0050; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R10 busy after accept", 32'(busy), 32'd1);
        @(negedge clk);
        mode = 4'd1; konst = 16'hDEAD; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done) @(negedge clk);
        @(negedge clk);
        repeat (4) begin
            check(!busy && !done, "R10 ignored start idle", {30'd0, busy, done}, 32'd0);
            @(negedge clk);
        end
        check(exp_q.size() == 0, "R11 all results delivered", 32'(exp_q.size()), 32'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule